// File: doc/BRIEF.md
# Framebuffer Control Register File

This block is the register file of a palette-based framebuffer controller. A host reaches it through a simple 32-bit word bus with an address, write data, a write strobe, a read strobe and read data. It stores three lookup tables: the colour palette, the small cursor palette and the cursor bitmap. It also holds the scalar settings for scan-out: picture width and height, the control word, the frame start address and the cursor position.

The scan-out logic sees the stored settings on dedicated outputs, along with a decoded bits-per-pixel value. It also gets its own synchronous read port into each table. Writes to the timing-generator offsets are accepted but not stored. The controller raises a frame interrupt when the scan-out side signals the end of a frame, and any bus write lowers it. A write to the soft-reset location returns the block to its power-up contents. The tables are cleared by a zeroing sweep that walks every table address, so they can stay inferable as block RAM.

Top module: `fbcfg_regs`

## Requirements
- R1: After `rst`, `cfg_width`, `cfg_height`, `cfg_ctrl`, `cfg_top`, `cfg_cursor_pos`, `cfg_blank`, `cfg_cursor_off`, `irq`, `bus_err` and `bus_rdata` are zero, and `cfg_depth` is 1. Once a zeroing sweep of max(PAL_DEPTH, PAT_DEPTH) cycles has run, every table entry reads zero.
- R2: A write to byte offsets 0x800..0x800+8*PAL_DEPTH-1 stores colour entry (addr-0x800)>>3, taking red from data bits 23:16, green from 15:8 and blue from 7:0. `pal_rdata` returns that entry as {red,green,blue} one cycle after `pal_raddr` presents its index.
- R3: Offsets 0x508..0x51F hold three cursor colours at an 8-byte stride, indexed by (addr-0x508)>>3, with the same RGB packing. A bus read returns the entry in bits 23:0 with bits 31:24 zero. `cpal_rdata` returns the entry one cycle after `cpal_raddr`.
- R4: Offsets 0x1000..0x1000+8*PAT_DEPTH-1 hold 16-bit cursor bitmap words at index (addr-0x1000)>>3, stored from data bits 15:0. A bus read returns the word zero-extended, and `pat_rdata` returns it one cycle after `pat_raddr`.
- R5: A write of v to offset 0x118 sets `cfg_width` to 4*v, truncated to DIM_W bits. A read of 0x118 returns `cfg_width`/4.
- R6: A write of v to offset 0x150 sets `cfg_height` to v/2, so bit 0 is dropped. A read of 0x150 returns 2*`cfg_height`.
- R7: Offset 0x300 is the control word. It is readable, `cfg_blank` is its bit 10 and `cfg_cursor_off` is its bit 23. Bits 22:20 give `cfg_depth` as follows: code 0..7 maps to 1, 2, 4, 8, 15, 16, 0, 0.
- R8: Writes to 0x400 and 0x638 set `cfg_top` and `cfg_cursor_pos`. Reads of these offsets return zero and flag an error.
- R9: Writes to 0x000, 0x108, 0x110, 0x120..0x148 (step 8), 0x158..0x170 (step 8) and 0x200 change no output and raise no error.
- R10: A write to 0x100000 clears all scalar settings and `irq` at the next cycle, and starts the zeroing sweep of all three tables.
- R11: `frame_tick` sets `irq` at the next clock edge. Any bus write clears it, and a write in the same cycle as `frame_tick` wins.
- R12: A write to an undefined offset changes nothing. A read of an offset that is not readable returns zero. Either access makes `bus_err` high for exactly the one cycle after it.
- R13: Read data is presented the cycle after `bus_re` and is zero in every other cycle. When `bus_we` and `bus_re` are both high, the write is performed and the read is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, cycle after `bus_re` |
| bus_err | output | 1 | One-cycle pulse after an undefined access |
| frame_tick | input | 1 | End-of-frame pulse from scan-out |
| irq | output | 1 | Frame interrupt |
| cfg_width | output | DIM_W | Picture width in pixels |
| cfg_height | output | DIM_W | Picture height in lines |
| cfg_ctrl | output | 32 | Control word |
| cfg_top | output | 32 | Frame start address |
| cfg_cursor_pos | output | 32 | Cursor position word |
| cfg_depth | output | 5 | Decoded bits per pixel |
| cfg_blank | output | 1 | Forced blanking |
| cfg_cursor_off | output | 1 | Cursor disabled |
| pal_raddr | input | $clog2(PAL_DEPTH) | Scan-out colour index |
| pal_rdata | output | 24 | Colour entry {R,G,B} |
| cpal_raddr | input | 2 | Scan-out cursor colour index |
| cpal_rdata | output | 24 | Cursor colour {R,G,B} |
| pat_raddr | input | $clog2(PAT_DEPTH) | Scan-out bitmap index |
| pat_rdata | output | 16 | Cursor bitmap word |

## Verification
Several properties are checked on every cycle:
- the interrupt falls after any write and rises after an unopposed frame tick;
- a soft-reset write empties every scalar setting one cycle later;
- an error pulse always follows some access and comes with zero read data;
- the zeroing sweep advances one address per cycle until it ends.

The address map itself can only be shown by the directed scenarios. These cover the scaled width and height encodings, the depth table, the index arithmetic inside each table window, the timing offsets that are silently dropped, and the fact that the tables read zero once the sweep has finished.

// File: rtl/fbcfg_pkg.sv
package fbcfg_pkg;

  typedef enum logic [3:0] {
    RG_NONE, RG_PAL, RG_CPAL, RG_PAT, RG_WIDTH, RG_HEIGHT,
    RG_CTRL, RG_TOP, RG_CPOS, RG_TIMING, RG_SRST
  } region_e;

  // byte offsets the scan-out software relies on
  localparam int unsigned OFS_PAL    = 32'h0000_0800;
  localparam int unsigned OFS_CPAL   = 32'h0000_0508;
  localparam int unsigned OFS_PAT    = 32'h0000_1000;
  localparam int unsigned OFS_WIDTH  = 32'h0000_0118;
  localparam int unsigned OFS_HEIGHT = 32'h0000_0150;
  localparam int unsigned OFS_CTRL   = 32'h0000_0300;
  localparam int unsigned OFS_TOP    = 32'h0000_0400;
  localparam int unsigned OFS_CPOS   = 32'h0000_0638;
  localparam int unsigned OFS_SRST   = 32'h0010_0000;
  localparam int unsigned STRIDE     = 8;
  localparam int unsigned CPAL_SLOTS = 3;

  localparam int DEPTH_LSB      = 20;
  localparam int BLANK_BIT      = 10;
  localparam int CURSOR_OFF_BIT = 23;

  function automatic logic [4:0] depth_of(input logic [2:0] code);
    case (code)
      3'd0:    depth_of = 5'd1;
      3'd1:    depth_of = 5'd2;
      3'd2:    depth_of = 5'd4;
      3'd3:    depth_of = 5'd8;
      3'd4:    depth_of = 5'd15;
      3'd5:    depth_of = 5'd16;
      default: depth_of = 5'd0;
    endcase
  endfunction

endpackage

// File: rtl/fbcfg_decode.sv
module fbcfg_decode
  import fbcfg_pkg::*;
#(
  parameter int ADDR_W    = 21,
  parameter int PAL_DEPTH = 256,
  parameter int PAT_DEPTH = 512,
  parameter int PAL_AW    = 8,
  parameter int PAT_AW    = 9,
  parameter int CPAL_AW   = 2
) (
  input  logic [ADDR_W-1:0]  addr,
  output region_e            region,
  output logic [PAL_AW-1:0]  pal_idx,
  output logic [CPAL_AW-1:0] cpal_idx,
  output logic [PAT_AW-1:0]  pat_idx
);

  localparam int unsigned PAL_END  = OFS_PAL + PAL_DEPTH * STRIDE;
  localparam int unsigned PAT_END  = OFS_PAT + PAT_DEPTH * STRIDE;
  localparam int unsigned CPAL_END = OFS_CPAL + CPAL_SLOTS * STRIDE;

  logic in_pal, in_pat, in_cpal, is_timing;

  always_comb begin
    in_pal  = (addr >= ADDR_W'(OFS_PAL))  && (addr < ADDR_W'(PAL_END));
    in_pat  = (addr >= ADDR_W'(OFS_PAT))  && (addr < ADDR_W'(PAT_END));
    in_cpal = (addr >= ADDR_W'(OFS_CPAL)) && (addr < ADDR_W'(CPAL_END));
    is_timing = addr inside {ADDR_W'(32'h000), ADDR_W'(32'h108), ADDR_W'(32'h110),
                             ADDR_W'(32'h120), ADDR_W'(32'h128), ADDR_W'(32'h130),
                             ADDR_W'(32'h138), ADDR_W'(32'h140), ADDR_W'(32'h148),
                             ADDR_W'(32'h158), ADDR_W'(32'h160), ADDR_W'(32'h168),
                             ADDR_W'(32'h170), ADDR_W'(32'h200)};

    pal_idx  = PAL_AW'((addr - ADDR_W'(OFS_PAL)) >> 3);
    pat_idx  = PAT_AW'((addr - ADDR_W'(OFS_PAT)) >> 3);
    cpal_idx = CPAL_AW'((addr - ADDR_W'(OFS_CPAL)) >> 3);

    if (in_pal)                            region = RG_PAL;
    else if (in_pat)                       region = RG_PAT;
    else if (in_cpal)                      region = RG_CPAL;
    else if (addr == ADDR_W'(OFS_WIDTH))   region = RG_WIDTH;
    else if (addr == ADDR_W'(OFS_HEIGHT))  region = RG_HEIGHT;
    else if (addr == ADDR_W'(OFS_CTRL))    region = RG_CTRL;
    else if (addr == ADDR_W'(OFS_TOP))     region = RG_TOP;
    else if (addr == ADDR_W'(OFS_CPOS))    region = RG_CPOS;
    else if (addr == ADDR_W'(OFS_SRST))    region = RG_SRST;
    else if (is_timing)                    region = RG_TIMING;
    else                                   region = RG_NONE;
  end

endmodule

// File: rtl/fbcfg_ram.sv
module fbcfg_ram #(
  parameter int DW     = 24,
  parameter int AW     = 8,
  parameter bit A_READ = 1'b1
) (
  input  logic          clk,
  input  logic          a_we,
  input  logic [AW-1:0] a_addr,
  input  logic [DW-1:0] a_wdata,
  output logic [DW-1:0] a_rdata,
  input  logic [AW-1:0] b_addr,
  output logic [DW-1:0] b_rdata
);

  localparam int WORDS = 2 ** AW;

  logic [DW-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (a_we) mem[a_addr] <= a_wdata;
    b_rdata <= mem[b_addr];
  end

  generate
    if (A_READ) begin : g_port_a_read
      always_ff @(posedge clk) a_rdata <= mem[a_addr];
    end else begin : g_port_a_write_only
      assign a_rdata = '0;
    end
  endgenerate

endmodule

// File: rtl/fbcfg_sweep.sv
module fbcfg_sweep #(
  parameter int LEN = 512,
  parameter int CW  = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  output logic          active,
  output logic [CW-1:0] cnt
);

  always_ff @(posedge clk) begin
    if (rst || start) begin
      active <= 1'b1;
      cnt    <= '0;
    end else if (active) begin
      if (cnt == CW'(LEN - 1)) active <= 1'b0;
      else                     cnt    <= cnt + 1'b1;
    end
  end

  // R10
  sweep_step_chk: assert property (@(posedge clk) disable iff (rst || start)
    (active && cnt != CW'(LEN - 1)) |=> (active && cnt == $past(cnt) + 1'b1));

endmodule

// File: rtl/fbcfg_regs.sv
module fbcfg_regs
  import fbcfg_pkg::*;
#(
  parameter int ADDR_W    = 21,
  parameter int PAL_DEPTH = 256,
  parameter int PAT_DEPTH = 512,
  parameter int PAT_W     = 16,
  parameter int DIM_W     = 16,
  localparam int PAL_AW   = $clog2(PAL_DEPTH),
  localparam int PAT_AW   = $clog2(PAT_DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  input  logic              bus_we,
  input  logic              bus_re,
  output logic [31:0]       bus_rdata,
  output logic              bus_err,
  input  logic              frame_tick,
  output logic              irq,
  output logic [DIM_W-1:0]  cfg_width,
  output logic [DIM_W-1:0]  cfg_height,
  output logic [31:0]       cfg_ctrl,
  output logic [31:0]       cfg_top,
  output logic [31:0]       cfg_cursor_pos,
  output logic [4:0]        cfg_depth,
  output logic              cfg_blank,
  output logic              cfg_cursor_off,
  input  logic [PAL_AW-1:0] pal_raddr,
  output logic [23:0]       pal_rdata,
  input  logic [1:0]        cpal_raddr,
  output logic [23:0]       cpal_rdata,
  input  logic [PAT_AW-1:0] pat_raddr,
  output logic [PAT_W-1:0]  pat_rdata
);

  localparam int CPAL_AW = 2;
  localparam int RGB_W   = 24;
  localparam int CLR_LEN = (PAL_DEPTH > PAT_DEPTH) ? PAL_DEPTH : PAT_DEPTH;
  localparam int CLR_W   = $clog2(CLR_LEN);

  region_e             region, rd_sel_q;
  logic [PAL_AW-1:0]   pal_idx;
  logic [CPAL_AW-1:0]  cpal_idx;
  logic [PAT_AW-1:0]   pat_idx;
  logic                wr, rd, srst_wr, readable;
  logic                clr_active;
  logic [CLR_W-1:0]    clr_cnt;
  logic [31:0]         reg_rd_q;
  logic [RGB_W-1:0]    pal_a_rdata, cpal_a_rdata;
  logic [PAT_W-1:0]    pat_a_rdata;

  assign wr      = bus_we;
  assign rd      = bus_re && !bus_we;
  assign srst_wr = wr && (region == RG_SRST);
  assign readable = region inside {RG_CPAL, RG_PAT, RG_WIDTH, RG_HEIGHT, RG_CTRL};

  fbcfg_decode #(
    .ADDR_W(ADDR_W), .PAL_DEPTH(PAL_DEPTH), .PAT_DEPTH(PAT_DEPTH),
    .PAL_AW(PAL_AW), .PAT_AW(PAT_AW), .CPAL_AW(CPAL_AW)
  ) u_decode (
    .addr(bus_addr), .region(region),
    .pal_idx(pal_idx), .cpal_idx(cpal_idx), .pat_idx(pat_idx)
  );

  fbcfg_sweep #(.LEN(CLR_LEN), .CW(CLR_W)) u_sweep (
    .clk(clk), .rst(rst), .start(srst_wr), .active(clr_active), .cnt(clr_cnt)
  );

  // ---------------- tables ----------------
  fbcfg_ram #(.DW(RGB_W), .AW(PAL_AW), .A_READ(1'b0)) u_pal (
    .clk(clk),
    .a_we(clr_active || (wr && region == RG_PAL)),
    .a_addr(clr_active ? PAL_AW'(clr_cnt) : pal_idx),
    .a_wdata(clr_active ? '0 : bus_wdata[RGB_W-1:0]),
    .a_rdata(pal_a_rdata),
    .b_addr(pal_raddr), .b_rdata(pal_rdata)
  );

  fbcfg_ram #(.DW(RGB_W), .AW(CPAL_AW), .A_READ(1'b1)) u_cpal (
    .clk(clk),
    .a_we(clr_active || (wr && region == RG_CPAL)),
    .a_addr(clr_active ? CPAL_AW'(clr_cnt) : cpal_idx),
    .a_wdata(clr_active ? '0 : bus_wdata[RGB_W-1:0]),
    .a_rdata(cpal_a_rdata),
    .b_addr(cpal_raddr), .b_rdata(cpal_rdata)
  );

  fbcfg_ram #(.DW(PAT_W), .AW(PAT_AW), .A_READ(1'b1)) u_pat (
    .clk(clk),
    .a_we(clr_active || (wr && region == RG_PAT)),
    .a_addr(clr_active ? PAT_AW'(clr_cnt) : pat_idx),
    .a_wdata(clr_active ? '0 : bus_wdata[PAT_W-1:0]),
    .a_rdata(pat_a_rdata),
    .b_addr(pat_raddr), .b_rdata(pat_rdata)
  );

  // ---------------- scalar settings ----------------
  always_ff @(posedge clk) begin
    if (rst || srst_wr) begin
      cfg_width      <= '0;
      cfg_height     <= '0;
      cfg_ctrl       <= '0;
      cfg_top        <= '0;
      cfg_cursor_pos <= '0;
      cfg_depth      <= depth_of(3'd0);
    end else if (wr) begin
      case (region)
        RG_WIDTH:  cfg_width  <= {bus_wdata[DIM_W-3:0], 2'b00};
        RG_HEIGHT: cfg_height <= bus_wdata[DIM_W:1];
        RG_CTRL: begin
          cfg_ctrl  <= bus_wdata;
          cfg_depth <= depth_of(bus_wdata[DEPTH_LSB +: 3]);
        end
        RG_TOP:    cfg_top        <= bus_wdata;
        RG_CPOS:   cfg_cursor_pos <= bus_wdata;
        default: ;
      endcase
    end
  end

  assign cfg_blank      = cfg_ctrl[BLANK_BIT];
  assign cfg_cursor_off = cfg_ctrl[CURSOR_OFF_BIT];

  // ---------------- interrupt ----------------
  always_ff @(posedge clk) begin
    if (rst || wr)       irq <= 1'b0;
    else if (frame_tick) irq <= 1'b1;
  end

  // ---------------- read path and error ----------------
  always_ff @(posedge clk) begin
    if (rst) begin
      bus_err  <= 1'b0;
      rd_sel_q <= RG_NONE;
      reg_rd_q <= '0;
    end else begin
      bus_err  <= (wr && region == RG_NONE) || (rd && !readable);
      rd_sel_q <= rd ? region : RG_NONE;
      case (region)
        RG_WIDTH:  reg_rd_q <= 32'(cfg_width >> 2);
        RG_HEIGHT: reg_rd_q <= 32'({cfg_height, 1'b0});
        RG_CTRL:   reg_rd_q <= cfg_ctrl;
        default:   reg_rd_q <= '0;
      endcase
    end
  end

  always_comb begin
    case (rd_sel_q)
      RG_PAL:                      bus_rdata = 32'(pal_a_rdata);
      RG_CPAL:                     bus_rdata = 32'(cpal_a_rdata);
      RG_PAT:                      bus_rdata = 32'(pat_a_rdata);
      RG_WIDTH, RG_HEIGHT, RG_CTRL: bus_rdata = reg_rd_q;
      default:                     bus_rdata = '0;
    endcase
  end

  // ---------------- assertions ----------------
  // R11
  irq_clear_chk: assert property (@(posedge clk) disable iff (rst)
    bus_we |=> !irq);

  // R11
  irq_set_chk: assert property (@(posedge clk) disable iff (rst)
    (frame_tick && !bus_we) |=> irq);

  // R10
  soft_reset_chk: assert property (@(posedge clk) disable iff (rst)
    srst_wr |=> (cfg_width == '0 && cfg_height == '0 && cfg_ctrl == '0 &&
                 cfg_top == '0 && cfg_cursor_pos == '0 && !irq));

  // R12
  err_cause_chk: assert property (@(posedge clk) disable iff (rst)
    bus_err |-> $past(bus_we || bus_re));

  // R12
  err_zero_data_chk: assert property (@(posedge clk) disable iff (rst)
    bus_err |-> (bus_rdata == '0));

endmodule

// File: tb/fbcfg_regs_bench.sv
module fbcfg_regs_bench;

  localparam int ADDR_W = 21;
  localparam int CLR    = 512;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_we = 1'b0, bus_re = 1'b0, frame_tick = 1'b0;
  logic [31:0] bus_rdata;
  logic        bus_err, irq, cfg_blank, cfg_cursor_off;
  logic [15:0] cfg_width, cfg_height;
  logic [31:0] cfg_ctrl, cfg_top, cfg_cursor_pos;
  logic [4:0]  cfg_depth;
  logic [7:0]  pal_raddr = '0;
  logic [1:0]  cpal_raddr = '0;
  logic [8:0]  pat_raddr = '0;
  logic [23:0] pal_rdata, cpal_rdata;
  logic [15:0] pat_rdata;

  int n_chk = 0, n_fail = 0;
  logic [31:0] rd_val;
  logic        rd_err, wr_err;

  always #5 clk = ~clk;

  fbcfg_regs u_fbcfg_regs (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata), .bus_err(bus_err),
    .frame_tick(frame_tick), .irq(irq), .cfg_width(cfg_width),
    .cfg_height(cfg_height), .cfg_ctrl(cfg_ctrl), .cfg_top(cfg_top),
    .cfg_cursor_pos(cfg_cursor_pos), .cfg_depth(cfg_depth),
    .cfg_blank(cfg_blank), .cfg_cursor_off(cfg_cursor_off),
    .pal_raddr(pal_raddr), .pal_rdata(pal_rdata),
    .cpal_raddr(cpal_raddr), .cpal_rdata(cpal_rdata),
    .pat_raddr(pat_raddr), .pat_rdata(pat_rdata)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
    wr_err = bus_err;
  endtask

  task automatic bus_rd(input logic [ADDR_W-1:0] a);
    @(negedge clk);
    bus_addr = a; bus_re = 1'b1;
    @(negedge clk);
    rd_val = bus_rdata; rd_err = bus_err;
    bus_re = 1'b0;
  endtask

  task automatic scan(input logic [7:0] p, input logic [1:0] c, input logic [8:0] t);
    @(negedge clk);
    pal_raddr = p; cpal_raddr = c; pat_raddr = t;
    @(negedge clk);
  endtask

  task automatic t_reset();
    repeat (4) @(negedge clk);
    rst = 1'b0;
    chk("R1 width", 32'(cfg_width), 0);
    chk("R1 height", 32'(cfg_height), 0);
    chk("R1 ctrl", cfg_ctrl, 0);
    chk("R1 top", cfg_top, 0);
    chk("R1 cpos", cfg_cursor_pos, 0);
    chk("R1 depth", 32'(cfg_depth), 1);
    chk("R1 flags", {28'b0, irq, bus_err, cfg_blank, cfg_cursor_off}, 0);
    chk("R1 rdata", bus_rdata, 0);
    repeat (CLR + 8) @(negedge clk);
    scan(8'd255, 2'd2, 9'd511);
    chk("R1 pal cleared", 32'(pal_rdata), 0);
    chk("R1 cpal cleared", 32'(cpal_rdata), 0);
    chk("R1 pat cleared", 32'(pat_rdata), 0);
  endtask

  task automatic t_palette();
    bus_wr(21'h828, 32'hFFA1B2C3);
    chk("R2 no err", 32'(wr_err), 0);
    bus_wr(21'hFFF, 32'h00112233);
    bus_wr(21'h832, 32'h00405060);
    scan(8'd5, 2'd0, 9'd0);
    chk("R2 entry 5", 32'(pal_rdata), 32'hA1B2C3);
    scan(8'd255, 2'd0, 9'd0);
    chk("R2 entry 255", 32'(pal_rdata), 32'h112233);
    scan(8'd6, 2'd0, 9'd0);
    chk("R2 entry 6", 32'(pal_rdata), 32'h405060);
  endtask

  task automatic t_cursor_pal();
    bus_wr(21'h510, 32'hFF445566);
    bus_wr(21'h51F, 32'h00778899);
    bus_wr(21'h508, 32'h00010203);
    bus_rd(21'h510);
    chk("R3 readback 1", rd_val, 32'h00445566);
    chk("R3 readback err", 32'(rd_err), 0);
    bus_rd(21'h518);
    chk("R3 readback 2", rd_val, 32'h00778899);
    scan(8'd0, 2'd0, 9'd0);
    chk("R3 scan 0", 32'(cpal_rdata), 32'h010203);
    scan(8'd0, 2'd2, 9'd0);
    chk("R3 scan 2", 32'(cpal_rdata), 32'h778899);
  endtask

  task automatic t_pattern();
    bus_wr(21'h1960, 32'hDEADBEEF);
    bus_wr(21'h1FF8, 32'h00005A5A);
    bus_rd(21'h1960);
    chk("R4 readback", rd_val, 32'h0000BEEF);
    bus_rd(21'h1FFC);
    chk("R4 readback last", rd_val, 32'h00005A5A);
    scan(8'd0, 2'd0, 9'd300);
    chk("R4 scan", 32'(pat_rdata), 32'hBEEF);
  endtask

  task automatic t_dims();
    bus_wr(21'h118, 32'h140);
    chk("R5 width", 32'(cfg_width), 32'h500);
    bus_rd(21'h118);
    chk("R5 width read", rd_val, 32'h140);
    bus_wr(21'h118, 32'h5001);
    chk("R5 width trunc", 32'(cfg_width), 32'h4004);
    bus_wr(21'h150, 32'h3C1);
    chk("R6 height", 32'(cfg_height), 32'h1E0);
    bus_rd(21'h150);
    chk("R6 height read", rd_val, 32'h3C0);
  endtask

  task automatic t_ctrl();
    logic [4:0] tbl [8] = '{5'd1, 5'd2, 5'd4, 5'd8, 5'd15, 5'd16, 5'd0, 5'd0};
    for (int code = 0; code < 8; code++) begin
      bus_wr(21'h300, 32'(code) << 20);
      chk($sformatf("R7 depth code %0d", code), 32'(cfg_depth), 32'(tbl[code]));
    end
    bus_wr(21'h300, 32'h00B00400);
    chk("R7 depth", 32'(cfg_depth), 8);
    chk("R7 blank", 32'(cfg_blank), 1);
    chk("R7 cursor off", 32'(cfg_cursor_off), 1);
    bus_rd(21'h300);
    chk("R7 readback", rd_val, 32'h00B00400);
  endtask

  task automatic t_top_cpos();
    bus_wr(21'h400, 32'h0012_3400);
    chk("R8 top", cfg_top, 32'h0012_3400);
    bus_wr(21'h638, 32'h0640_0200);
    chk("R8 cpos", cfg_cursor_pos, 32'h0640_0200);
    bus_rd(21'h400);
    chk("R8 top read data", rd_val, 0);
    chk("R8 top read err", 32'(rd_err), 1);
  endtask

  task automatic t_timing();
    logic [ADDR_W-1:0] offs [5] = '{21'h000, 21'h108, 21'h148, 21'h170, 21'h200};
    for (int i = 0; i < 5; i++) begin
      bus_wr(offs[i], 32'hFFFF_FFFF);
      chk("R9 no err", 32'(wr_err), 0);
    end
    chk("R9 width kept", 32'(cfg_width), 32'h4004);
    chk("R9 ctrl kept", cfg_ctrl, 32'h00B00400);
    chk("R9 top kept", cfg_top, 32'h0012_3400);
    chk("R9 cpos kept", cfg_cursor_pos, 32'h0640_0200);
  endtask

  task automatic t_undefined();
    bus_wr(21'h700, 32'hFFFF_FFFF);
    chk("R12 write err", 32'(wr_err), 1);
    @(negedge clk);
    chk("R12 err one cycle", 32'(bus_err), 0);
    chk("R12 height kept", 32'(cfg_height), 32'h1E0);
    chk("R12 ctrl kept", cfg_ctrl, 32'h00B00400);
    bus_rd(21'h704);
    chk("R12 read zero", rd_val, 0);
    chk("R12 read err", 32'(rd_err), 1);
    bus_rd(21'h828);
    chk("R12 palette read zero", rd_val, 0);
    chk("R12 palette read err", 32'(rd_err), 1);
  endtask

  task automatic t_latency();
    bus_rd(21'h300);
    chk("R13 data in slot", rd_val, 32'h00B00400);
    @(negedge clk);
    chk("R13 data gone", bus_rdata, 0);
    @(negedge clk);
    bus_addr = 21'h150; bus_wdata = 32'h100; bus_we = 1'b1; bus_re = 1'b1;
    @(negedge clk);
    bus_we = 1'b0; bus_re = 1'b0;
    chk("R13 write wins", 32'(cfg_height), 32'h80);
    chk("R13 read dropped", bus_rdata, 0);
  endtask

  task automatic t_irq();
    @(negedge clk); frame_tick = 1'b1;
    @(negedge clk); frame_tick = 1'b0;
    chk("R11 irq set", 32'(irq), 1);
    repeat (2) @(negedge clk);
    chk("R11 irq held", 32'(irq), 1);
    bus_wr(21'h108, 32'h1);
    chk("R11 irq cleared", 32'(irq), 0);
    @(negedge clk);
    frame_tick = 1'b1; bus_addr = 21'h110; bus_we = 1'b1;
    @(negedge clk);
    frame_tick = 1'b0; bus_we = 1'b0;
    chk("R11 write wins", 32'(irq), 0);
  endtask

  task automatic t_srst();
    @(negedge clk); frame_tick = 1'b1;
    @(negedge clk); frame_tick = 1'b0;
    bus_wr(21'h100000, 32'h0);
    chk("R10 width", 32'(cfg_width), 0);
    chk("R10 height", 32'(cfg_height), 0);
    chk("R10 ctrl", cfg_ctrl, 0);
    chk("R10 top", cfg_top, 0);
    chk("R10 cpos", cfg_cursor_pos, 0);
    chk("R10 depth", 32'(cfg_depth), 1);
    chk("R10 irq", 32'(irq), 0);
    repeat (CLR + 8) @(negedge clk);
    scan(8'd5, 2'd1, 9'd300);
    chk("R10 pal wiped", 32'(pal_rdata), 0);
    chk("R10 cpal wiped", 32'(cpal_rdata), 0);
    chk("R10 pat wiped", 32'(pat_rdata), 0);
    bus_rd(21'h1960);
    chk("R10 pat read wiped", rd_val, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_palette();
    t_cursor_pal();
    t_pattern();
    t_dims();
    t_ctrl();
    t_top_cpos();
    t_timing();
    t_undefined();
    t_latency();
    t_irq();
    t_srst();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule